// File: doc/BRIEF.md
# Instruction Cycle Sequencer and Field Decoder

This block paces a small processor core. It divides the oscillator clock into a repeating four-phase instruction cycle and drives one strobe per phase. At the end of every cycle it captures the 14-bit word that was fetched, together with a format class that an upstream opcode decoder supplies. During the next cycle it presents that word's operand fields: the opcode bits, the file address, the bit index, and an immediate of eight or eleven bits. It also presents a pair of destination selects that send a byte result either to the working register or back to the addressed file register.

When the core reports a taken skip or a change of program counter on `redirect`, the word fetched for the next cycle is discarded. An all-zero no-operation is latched in its place and `flush` is raised for that whole cycle. The affected instruction therefore takes two cycles. The ALU, the register file, program memory, the stack and the full opcode table sit outside this block.

Top module: `instr_cycle_seq`

## Requirements
- R1: Synchronous reset, active high on `rst`, puts the sequencer in its first phase (`phase_stb` = 4'b0001) and clears `flush`. The decoded word becomes an all-zero word of the byte class, so opcode, file address, bit index and immediate are 0, `to_wreg` is 1 and `to_file` is 0.
- R2: `phase_stb` is one-hot. Each bit is high for exactly one clock, and the order is bit 0, bit 1, bit 2, bit 3, then bit 0 again.
- R3: A new word and class are captured only on the clock edge that ends phase 4 (`phase_stb[3]` high). All decoded outputs stay unchanged for the four clocks of the following cycle.
- R4: Byte class (`fetch_class` = 0): `opcode` = word[13:8], `file_addr` = word[6:0], and the bit index and immediate are 0.
- R5: In the byte class, word[7] = 0 gives `to_wreg`=1 and `to_file`=0, and word[7] = 1 gives `to_wreg`=0 and `to_file`=1. In every other class, and during a flush, both selects are 0.
- R6: Bit class (`fetch_class` = 1): `opcode` = {2'b00, word[13:10]}, `bit_sel` = word[9:7], `file_addr` = word[6:0], and the immediate is 0.
- R7: Literal class (`fetch_class` = 2): `opcode` = word[13:8], `imm` = {3'b000, word[7:0]}, and the file address and bit index are 0.
- R8: Jump class (`fetch_class` = 3): `opcode` = {3'b000, word[13:11]}, `imm` = word[10:0], and the file address and bit index are 0.
- R9: Any output field that does not belong to the current class reads 0, whatever the word bits are, including a word of all ones.
- R10: If `redirect` is high at the edge that ends phase 4, the next cycle has `flush`=1 and every decoded field and both destination selects at 0, whatever word was fetched. Back-to-back redirects give back-to-back flushed cycles.
- R11: `redirect`, `fetch_word` and `fetch_class` have no effect while phases 1 to 3 are active. Outputs and `flush` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 14 | Fetched instruction word, sampled at the end of phase 4 |
| fetch_class | input | 2 | Format class: 0 byte, 1 bit, 2 literal, 3 jump |
| redirect | input | 1 | Skip taken or program counter changed, sampled at the end of phase 4 |
| phase_stb | output | 4 | One-hot phase strobes |
| flush | output | 1 | Current cycle is a forced no-operation |
| opcode | output | 6 | Opcode bits, right-aligned |
| file_addr | output | 7 | File register address |
| bit_sel | output | 3 | Bit index within the file register |
| imm | output | 11 | Immediate, 8-bit literals zero-extended |
| to_wreg | output | 1 | Byte result goes to the working register |
| to_file | output | 1 | Byte result goes back to the file register |

## Verification
The hardest case to reach from the ports is a `redirect` pulse that arrives in a phase other than the last. It must be ignored, even though the same pulse one clock later would flush the next cycle. The stimulus drives random noise on `redirect`, `fetch_word` and `fetch_class` during phases 1 to 3 of every cycle. One directed cycle holds `redirect` high through those phases and drops it only for the last one. Every phase of the following cycle is then checked for an unchanged `flush` and unchanged fields. Directed cycles also send an all-ones word in each class and two consecutive redirects.

// File: rtl/icd_pkg.sv
package icd_pkg;

    localparam int WORD_W = 14;
    localparam int OPC_W  = 6;
    localparam int FILE_W = 7;
    localparam int BIT_W  = 3;
    localparam int LIT_W  = 8;
    localparam int IMM_W  = 11;
    localparam int CLS_W  = 2;

    // bit positions of the formats
    localparam int DEST_POS     = FILE_W;                 // 7
    localparam int BIT_LO       = FILE_W;                 // 7
    localparam int BIT_OPC_LO   = FILE_W + BIT_W;         // 10
    localparam int BYTE_OPC_LO  = FILE_W + 1;             // 8
    localparam int JUMP_OPC_LO  = IMM_W;                  // 11
    localparam int BIT_OPC_W    = WORD_W - BIT_OPC_LO;    // 4
    localparam int JUMP_OPC_W   = WORD_W - JUMP_OPC_LO;   // 3

    typedef enum logic [CLS_W-1:0] {
        CLS_BYTE = 2'd0,
        CLS_BIT  = 2'd1,
        CLS_LIT  = 2'd2,
        CLS_JUMP = 2'd3
    } fmt_cls_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [FILE_W-1:0] file_addr;
        logic [BIT_W-1:0]  bit_sel;
        logic [IMM_W-1:0]  imm;
        logic              to_wreg;
        logic              to_file;
    } fields_t;

endpackage

// File: rtl/icd_phase_gen.sv
module icd_phase_gen #(
    parameter int PHASES = 4,
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PHASES-1:0] stb,
    output logic              last
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.phase = '0;
        end else if (st_q.phase == PH_W'(PHASES - 1)) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar i = 0; i < PHASES; i++) begin : g_stb
        assign stb[i] = (st_q.phase == PH_W'(i));

        // R2: each strobe hands over to its successor on the next clock
        assert_rotate_R2: assert property (@(posedge clk) disable iff (rst)
            stb[i] |=> stb[(i + 1) % PHASES]);
    end

    assign last = stb[PHASES-1];

    // R1: after a reset clock the first phase is active
    assert_reset_phase_R1: assert property (@(posedge clk)
        rst |=> (stb == PHASES'(1)));

endmodule

// File: rtl/icd_word_latch.sv
module icd_word_latch
    import icd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              last,
    input  logic [WORD_W-1:0] fetch_word,
    input  fmt_cls_e          fetch_class,
    input  logic              redirect,
    output logic [WORD_W-1:0] ir,
    output fmt_cls_e          cls,
    output logic              flushed
);

    typedef struct packed {
        logic [WORD_W-1:0] ir;
        fmt_cls_e          cls;
        logic              flushed;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ir      = '0;
            st_d.cls     = CLS_BYTE;
            st_d.flushed = 1'b0;
        end else if (last) begin
            if (redirect) begin
                st_d.ir      = '0;
                st_d.cls     = CLS_BYTE;
                st_d.flushed = 1'b1;
            end else begin
                st_d.ir      = fetch_word;
                st_d.cls     = fetch_class;
                st_d.flushed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ir      = st_q.ir;
    assign cls     = st_q.cls;
    assign flushed = st_q.flushed;

    // R3: the word only changes at the end of the last phase
    assert_hold_word_R3: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(ir) && $stable(cls));

    // R11: redirect outside the last phase leaves the flush state alone
    assert_ignore_redirect_R11: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(flushed));

    // R10: a redirect at the last phase yields a zeroed, flushed word
    assert_flush_word_R10: assert property (@(posedge clk) disable iff (rst)
        (last && redirect) |=> (flushed && ir == '0));

    // R1: reset clears any pending flush
    assert_reset_flush_R1: assert property (@(posedge clk)
        rst |=> !flushed);

endmodule

// File: rtl/icd_field_split.sv
module icd_field_split
    import icd_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    input  fmt_cls_e          cls,
    input  logic              flushed,
    output fields_t           fld
);

    always_comb begin
        fld = '0;
        if (!flushed) begin
            unique case (cls)
                CLS_BYTE: begin
                    fld.opcode    = ir[WORD_W-1:BYTE_OPC_LO];
                    fld.file_addr = ir[FILE_W-1:0];
                    fld.to_file   = ir[DEST_POS];
                    fld.to_wreg   = !ir[DEST_POS];
                end
                CLS_BIT: begin
                    fld.opcode    = OPC_W'(ir[WORD_W-1:BIT_OPC_LO]);
                    fld.bit_sel   = ir[BIT_OPC_LO-1:BIT_LO];
                    fld.file_addr = ir[FILE_W-1:0];
                end
                CLS_LIT: begin
                    fld.opcode    = ir[WORD_W-1:BYTE_OPC_LO];
                    fld.imm       = IMM_W'(ir[LIT_W-1:0]);
                end
                CLS_JUMP: begin
                    fld.opcode    = OPC_W'(ir[WORD_W-1:JUMP_OPC_LO]);
                    fld.imm       = ir[IMM_W-1:0];
                end
                default: fld = '0;
            endcase
        end
    end

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import icd_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic [CLS_W-1:0]  fetch_class,
    input  logic              redirect,
    output logic [PHASES-1:0] phase_stb,
    output logic              flush,
    output logic [OPC_W-1:0]  opcode,
    output logic [FILE_W-1:0] file_addr,
    output logic [BIT_W-1:0]  bit_sel,
    output logic [IMM_W-1:0]  imm,
    output logic              to_wreg,
    output logic              to_file
);

    logic              last;
    logic [WORD_W-1:0] ir;
    fmt_cls_e          cls;
    logic              flushed;
    fields_t           fld;

    icd_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .stb  (phase_stb),
        .last (last)
    );

    icd_word_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .last        (last),
        .fetch_word  (fetch_word),
        .fetch_class (fmt_cls_e'(fetch_class)),
        .redirect    (redirect),
        .ir          (ir),
        .cls         (cls),
        .flushed     (flushed)
    );

    icd_field_split u_split (
        .ir      (ir),
        .cls     (cls),
        .flushed (flushed),
        .fld     (fld)
    );

    assign flush     = flushed;
    assign opcode    = fld.opcode;
    assign file_addr = fld.file_addr;
    assign bit_sel   = fld.bit_sel;
    assign imm       = fld.imm;
    assign to_wreg   = fld.to_wreg;
    assign to_file   = fld.to_file;

    // R2: exactly one strobe at any time
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_stb) == 1);

    // R5: the two destinations never both selected
    assert_dest_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(to_wreg && to_file));

    // R10: a flushed cycle drives no field and no destination
    assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        flush |-> (opcode == '0 && file_addr == '0 && imm == '0 &&
                   bit_sel == '0 && !to_wreg && !to_file));

    // R9: bit index only in bit class, destinations only in byte class
    assert_foreign_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (cls != CLS_BIT) |-> (bit_sel == '0));
    assert_dest_class_R9: assert property (@(posedge clk) disable iff (rst)
        (cls != CLS_BYTE) |-> (!to_wreg && !to_file));

endmodule

// File: tb/instr_cycle_seq_bench.sv
module instr_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_INSTR    = 400;
    localparam int WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] fetch_word = '0;
    logic [1:0]  fetch_class = '0;
    logic        redirect = 1'b0;
    logic [3:0]  phase_stb;
    logic        flush;
    logic [5:0]  opcode;
    logic [6:0]  file_addr;
    logic [2:0]  bit_sel;
    logic [10:0] imm;
    logic        to_wreg;
    logic        to_file;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_cycle_seq u_instr_cycle_seq (
        .clk (clk), .rst (rst), .fetch_word (fetch_word),
        .fetch_class (fetch_class), .redirect (redirect),
        .phase_stb (phase_stb), .flush (flush), .opcode (opcode),
        .file_addr (file_addr), .bit_sel (bit_sel), .imm (imm),
        .to_wreg (to_wreg), .to_file (to_file)
    );

    // {opcode6, file7, bit3, imm11, to_wreg, to_file}
    function automatic logic [28:0] model(input logic [13:0] w,
                                          input logic [1:0] c,
                                          input logic fl);
        logic [5:0] o; logic [6:0] f; logic [2:0] b; logic [10:0] k;
        logic tw, tf;
        o = '0; f = '0; b = '0; k = '0; tw = 0; tf = 0;
        if (!fl) begin
            case (c)
                2'd0: begin o = w[13:8]; f = w[6:0]; tw = ~w[7]; tf = w[7]; end
                2'd1: begin o = {2'b00, w[13:10]}; b = w[9:7]; f = w[6:0]; end
                2'd2: begin o = w[13:8]; k = {3'b000, w[7:0]}; end
                default: begin o = {3'b000, w[13:11]}; k = w[10:0]; end
            endcase
        end
        return {o, f, b, k, tw, tf};
    endfunction

    function automatic string cls_tag(input logic [1:0] c, input logic fl);
        if (fl) return "R10";
        case (c)
            2'd0: return "R4";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [28:0] dut_vec();
        return {opcode, file_addr, bit_sel, imm, to_wreg, to_file};
    endfunction

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2: watchdog expired, actual hang, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [28:0] exp_vec;
        logic        exp_fl;
        logic [1:0]  exp_cls;
        logic [13:0] w;
        logic [1:0]  c;
        logic        rd;
        logic        noise_hi;
        void'($urandom(32'h5EED_1CD0));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", 32'(phase_stb), 32'h1);
        check("R1", 32'(flush), 32'h0);
        check("R1", 32'(dut_vec()), 32'(model(14'h0, 2'd0, 1'b0)));

        exp_vec = model(14'h0, 2'd0, 1'b0);
        exp_fl  = 1'b0;
        exp_cls = 2'd0;

        for (int n = 0; n < N_INSTR; n++) begin
            w  = 14'($urandom);
            c  = 2'($urandom);
            rd = ($urandom % 4) == 0;
            noise_hi = 1'b0;
            case (n)
                0: begin w = 14'h3FFF; c = 2'd0; rd = 0; end   // R5 dest file, R9
                1: begin w = 14'h3FFF; c = 2'd1; rd = 0; end   // R9
                2: begin w = 14'h3FFF; c = 2'd2; rd = 0; end   // R9
                3: begin w = 14'h3FFF; c = 2'd3; rd = 0; end   // R9
                4: begin w = 14'h3F7F; c = 2'd0; rd = 0; end   // R5 dest wreg
                5: begin rd = 1; end                           // R10
                6: begin rd = 1; end                           // R10 back-to-back
                7: begin rd = 0; noise_hi = 1'b1; end          // R11 directed
                default: ;
            endcase

            for (int p = 0; p < 4; p++) begin
                check("R2", 32'(phase_stb), 32'(4'b0001 << p));
                check(p == 0 ? cls_tag(exp_cls, exp_fl) : "R3",
                      32'(dut_vec()), 32'(exp_vec));
                check(p == 0 ? "R10" : "R11", 32'(flush), 32'(exp_fl));
                if (p == 0) begin
                    check("R5", 32'({to_wreg, to_file}), 32'(exp_vec[1:0]));
                    check("R9", 32'(bit_sel), 32'(exp_vec[15:13]));
                end
                if (p < 3) begin
                    fetch_word  = 14'($urandom);
                    fetch_class = 2'($urandom);
                    redirect    = noise_hi ? 1'b1 : 1'($urandom);
                end else begin
                    fetch_word  = w;
                    fetch_class = c;
                    redirect    = rd;
                end
                @(posedge clk);
                @(negedge clk);
            end

            exp_vec = model(w, c, rd);
            exp_fl  = rd;
            exp_cls = c;
        end

        // final cycle observation
        check("R2", 32'(phase_stb), 32'h1);
        check(cls_tag(exp_cls, exp_fl), 32'(dut_vec()), 32'(exp_vec));
        check("R10", 32'(flush), 32'(exp_fl));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule